// File: doc/BRIEF.md
# Cascaded Segment Column Driver

This block models the column side of a multiplexed dot-matrix panel. It has two chains, upper and lower, and each chain is a row of driver slices. A line is sent as a stream of 4-bit nibbles, one nibble per falling edge of the shift clock. Only one slice per chain takes data at any time. When that slice has taken its quota, the selection moves to its right-hand neighbour. Slices that are not selected ignore the shift clock and the bus, which saves power in a real driver. Both chains share one selection sequence and load together, each from its own nibble bus.

A falling edge of the line strobe copies the shift contents of every slice into an output latch in one step. The same edge sends the selection back to the leftmost slice. The latch keeps the displayed line steady while the next line is shifted in. Each column output is the latched dot XORed with the polarity input. This is a digital model of the alternating drive that keeps DC off the panel.

All inputs are sampled on `clk`. An edge of the shift clock or the line strobe takes effect on the `clk` edge where the new low level is first seen.

Top module: `seg_column_driver`

## Requirements
- R1: After synchronous reset, every latched dot is 0 and `chain_full` is 0, so with `pol`=0 all columns read 0. Selection starts at slice 0.
- R2: A nibble is accepted only on a high-to-low change of `shift_clk`. A level held high or low, or a low-to-high change, accepts nothing.
- R3: An accepted nibble enters the selected slice's rightmost four columns, with nibble bit i going to the lower-numbered column plus i. The slice's existing 80 dots move four columns toward its left end, so after 20 nibbles the first one sits at the slice's leftmost columns. Column 0 is the leftmost column of the line.
- R4: Slice s (s = 0..7, 80 columns from column 80*s) accepts nibbles 20s to 20s+19 of a line. It then stops, and slice s+1 takes over. Slice contents outside the selected slice do not change.
- R5: After 160 accepted nibbles `chain_full` is 1 and further shift-clock edges change nothing until the next line strobe.
- R6: On the `clk` edge that first sees `line_stb` low after high, all 640 columns of both chains latch their shift contents at once.
- R7: The latched line does not change between line-strobe falling edges, even while nibbles are shifted in.
- R8: A line-strobe falling edge returns the selection to slice 0 and clears `chain_full`.
- R9: When a shift-clock fall and a line-strobe fall are seen on the same `clk` edge, the line is latched, the nibble is dropped and the selection restarts.
- R10: The upper chain loads from `nib_up` and the lower chain from `nib_lo` on the same edges.
- R11: Each column output equals its latched dot XOR `pol`. This is combinational, so a change of `pol` shows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk | input | 1 | Nibble shift clock, acts on its falling edge |
| line_stb | input | 1 | Line latch strobe, acts on its falling edge |
| pol | input | 1 | Drive polarity, inverts every column when 1 |
| nib_up | input | 4 | Upper chain nibble bus |
| nib_lo | input | 4 | Lower chain nibble bus |
| col_up | output | 640 | Upper chain column outputs, bit 0 leftmost |
| col_lo | output | 640 | Lower chain column outputs, bit 0 leftmost |
| chain_full | output | 1 | All slices have taken their nibbles for this line |

## Verification
Shifts and latches land on the `clk` edge that first samples the new low level of `shift_clk` or `line_stb`. The bench therefore drives that low level at a falling `clk` edge and reads the result 1 ns after the next rising edge. The bench's line model is updated at that same rising edge. `chain_full` follows the selection state in that same cycle. The polarity path is combinational, so those checks read the columns 1 ns after `pol` is changed, with no clock edge in between. Hold checks read the columns partway through a line and compare them with the last latched model.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;

    localparam int unsigned NIB_W_D      = 4;
    localparam int unsigned SLICE_NIBS_D = 20;
    localparam int unsigned N_SLICES_D   = 8;

    typedef struct packed {
        logic shift;
        logic latch;
    } seg_evt_t;

    function automatic logic is_fall(input logic prev_lvl, input logic cur_lvl);
        return prev_lvl & ~cur_lvl;
    endfunction

endpackage

// File: rtl/seg_edge_det.sv
module seg_edge_det
    import seg_drv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     shift_clk,
    input  logic     line_stb,
    output seg_evt_t evt
);

    logic sclk_q;
    logic stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            sclk_q <= shift_clk;
            stb_q  <= line_stb;
        end
    end

    // Latch has priority: a coincident shift is dropped.
    always_comb begin
        evt.latch = is_fall(stb_q, line_stb);
        evt.shift = is_fall(sclk_q, shift_clk) & ~evt.latch;
    end

endmodule

// File: rtl/seg_slice_sel.sv
module seg_slice_sel
    import seg_drv_pkg::*;
#(
    parameter int unsigned SLICE_NIBS = SLICE_NIBS_D,
    parameter int unsigned N_SLICES   = N_SLICES_D
) (
    input  logic                clk,
    input  logic                rst,
    input  seg_evt_t            evt,
    output logic [N_SLICES-1:0] sel,
    output logic                chain_full
);

    localparam int unsigned CNT_W = $clog2(SLICE_NIBS + 1);

    logic [N_SLICES-1:0] full;

    for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
        logic [CNT_W-1:0] cnt_q;
        logic             left_done;

        if (s == 0) begin : g_first
            assign left_done = 1'b1;
        end else begin : g_rest
            assign left_done = full[s-1];
        end

        assign full[s] = (cnt_q == CNT_W'(SLICE_NIBS));
        assign sel[s]  = left_done & ~full[s];

        always_ff @(posedge clk) begin
            if (rst || evt.latch) begin
                cnt_q <= '0;
            end else if (evt.shift && sel[s]) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign chain_full = full[N_SLICES-1];

endmodule

// File: rtl/seg_slice_store.sv
module seg_slice_store
    import seg_drv_pkg::*;
#(
    parameter int unsigned NIB_W      = NIB_W_D,
    parameter int unsigned SLICE_NIBS = SLICE_NIBS_D
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        shift_en,
    input  logic                        latch_en,
    input  logic [NIB_W-1:0]            nib,
    output logic [NIB_W*SLICE_NIBS-1:0] lat
);

    localparam int unsigned DOTS = NIB_W * SLICE_NIBS;

    logic [DOTS-1:0] sr_q;

    // NIB_W parallel paths; new data enters at the right end.
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (shift_en) begin
            sr_q <= {nib, sr_q[DOTS-1:NIB_W]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat <= '0;
        end else if (latch_en) begin
            lat <= sr_q;
        end
    end

endmodule

// File: rtl/seg_column_driver.sv
module seg_column_driver
    import seg_drv_pkg::*;
#(
    parameter int unsigned NIB_W      = NIB_W_D,
    parameter int unsigned SLICE_NIBS = SLICE_NIBS_D,
    parameter int unsigned N_SLICES   = N_SLICES_D,
    localparam int unsigned DOTS      = NIB_W * SLICE_NIBS,
    localparam int unsigned COLS      = DOTS * N_SLICES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_clk,
    input  logic            line_stb,
    input  logic            pol,
    input  logic [NIB_W-1:0] nib_up,
    input  logic [NIB_W-1:0] nib_lo,
    output logic [COLS-1:0] col_up,
    output logic [COLS-1:0] col_lo,
    output logic            chain_full
);

    seg_evt_t            evt;
    logic [N_SLICES-1:0] sel;
    logic [COLS-1:0]     lat_up;
    logic [COLS-1:0]     lat_lo;

    seg_edge_det u_edge (
        .clk       (clk),
        .rst       (rst),
        .shift_clk (shift_clk),
        .line_stb  (line_stb),
        .evt       (evt)
    );

    seg_slice_sel #(
        .SLICE_NIBS (SLICE_NIBS),
        .N_SLICES   (N_SLICES)
    ) u_sel (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .sel        (sel),
        .chain_full (chain_full)
    );

    for (genvar s = 0; s < N_SLICES; s++) begin : g_col
        seg_slice_store #(
            .NIB_W      (NIB_W),
            .SLICE_NIBS (SLICE_NIBS)
        ) u_up (
            .clk      (clk),
            .rst      (rst),
            .shift_en (evt.shift & sel[s]),
            .latch_en (evt.latch),
            .nib      (nib_up),
            .lat      (lat_up[s*DOTS +: DOTS])
        );

        seg_slice_store #(
            .NIB_W      (NIB_W),
            .SLICE_NIBS (SLICE_NIBS)
        ) u_lo (
            .clk      (clk),
            .rst      (rst),
            .shift_en (evt.shift & sel[s]),
            .latch_en (evt.latch),
            .nib      (nib_lo),
            .lat      (lat_lo[s*DOTS +: DOTS])
        );
    end

    assign col_up = lat_up ^ {COLS{pol}};
    assign col_lo = lat_lo ^ {COLS{pol}};

endmodule

// File: rtl/seg_column_driver_chk.sv
module seg_column_driver_chk #(
    parameter int unsigned N_SLICES = 8,
    parameter int unsigned COLS     = 640
) (
    input logic                clk,
    input logic                rst,
    input logic                shift_clk,
    input logic                line_stb,
    input logic                pol,
    input logic [COLS-1:0]     col_up,
    input logic                chain_full,
    input logic [N_SLICES-1:0] sel
);

    logic            sc_q;
    logic            ls_q;
    logic            sc_fall;
    logic            ls_fall;
    logic [COLS-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_q <= 1'b0;
            ls_q <= 1'b0;
        end else begin
            sc_q <= shift_clk;
            ls_q <= line_stb;
        end
    end

    assign sc_fall = sc_q & ~shift_clk;
    assign ls_fall = ls_q & ~line_stb;
    assign held    = col_up ^ {COLS{pol}};

    // R2: no shift-clock fall and no strobe fall leaves the selection alone
    a_r2_sel_quiet: assert property (@(posedge clk) disable iff (rst)
        (!sc_fall && !ls_fall) |=> $stable(sel));

    // R4: exactly one slice selected until the chain is full
    a_r4_one_sel: assert property (@(posedge clk) disable iff (rst)
        !chain_full |-> ($countones(sel) == 1));

    a_r4_none_when_full: assert property (@(posedge clk) disable iff (rst)
        chain_full |-> (sel == '0));

    // R5: a full chain stays full until the strobe
    a_r5_full_sticky: assert property (@(posedge clk) disable iff (rst)
        (chain_full && !ls_fall) |=> chain_full);

    // R7: latched line only moves on a strobe fall
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (rst)
        !ls_fall |=> $stable(held));

    // R8: strobe restarts selection at slice 0
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        ls_fall |=> (!chain_full && sel[0]));

endmodule

bind seg_column_driver seg_column_driver_chk #(
    .N_SLICES (N_SLICES),
    .COLS     (COLS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_clk  (shift_clk),
    .line_stb   (line_stb),
    .pol        (pol),
    .col_up     (col_up),
    .chain_full (chain_full),
    .sel        (sel)
);

// File: tb/tb_seg_column_driver.sv
module tb_seg_column_driver;

    localparam int COLS  = 640;
    localparam int SDOTS = 80;
    localparam int SNIBS = 20;
    localparam int LNIBS = 160;

    // {nibble count[24:17], upper seed[16:9], lower seed[8:1], pol[0]}
    localparam logic [24:0] LINES [5] = '{
        {8'd160, 8'h13, 8'h9A, 1'b0},
        {8'd45,  8'h55, 8'h21, 1'b1},
        {8'd170, 8'h07, 8'hE4, 1'b0},
        {8'd20,  8'hC3, 8'h3C, 1'b1},
        {8'd160, 8'hA5, 8'h5A, 1'b1}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            shift_clk = 1'b0;
    logic            line_stb = 1'b0;
    logic            pol = 1'b0;
    logic [3:0]      nib_up = '0;
    logic [3:0]      nib_lo = '0;
    logic [COLS-1:0] col_up;
    logic [COLS-1:0] col_lo;
    logic            chain_full;

    logic [COLS-1:0] sh_up = '0, sh_lo = '0, lt_up = '0, lt_lo = '0;
    int              cnt = 0;
    int              checks = 0;
    int              failures = 0;
    bit              done = 1'b0;

    always #10 clk = ~clk;

    seg_column_driver dut (
        .clk        (clk),
        .rst        (rst),
        .shift_clk  (shift_clk),
        .line_stb   (line_stb),
        .pol        (pol),
        .nib_up     (nib_up),
        .nib_lo     (nib_lo),
        .col_up     (col_up),
        .col_lo     (col_lo),
        .chain_full (chain_full)
    );

    function automatic logic [3:0] gen(input logic [7:0] seed, input int k);
        return 4'((int'(seed) * 7 + k * 5 + (k >> 2)) & 15);
    endfunction

    task automatic chk_v(input string req, input logic [COLS-1:0] act, input logic [COLS-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic chk_b(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic chk_cols(input string req);
        chk_v({req, " upper"}, col_up, lt_up ^ {COLS{pol}});
        chk_v({req, " lower"}, col_lo, lt_lo ^ {COLS{pol}});
    endtask

    task automatic model_shift(input logic [3:0] nu, input logic [3:0] nl);
        if (cnt < LNIBS) begin
            int s = cnt / SNIBS;
            sh_up[s*SDOTS +: SDOTS] = {nu, sh_up[s*SDOTS+4 +: SDOTS-4]};
            sh_lo[s*SDOTS +: SDOTS] = {nl, sh_lo[s*SDOTS+4 +: SDOTS-4]};
            cnt++;
        end
    endtask

    task automatic model_latch();
        lt_up = sh_up;
        lt_lo = sh_lo;
        cnt   = 0;
    endtask

    task automatic send_nib(input logic [3:0] nu, input logic [3:0] nl);
        @(negedge clk);
        nib_up    = nu;
        nib_lo    = nl;
        shift_clk = 1'b1;
        @(negedge clk);
        shift_clk = 1'b0;
        @(posedge clk);
        #1;
        model_shift(nu, nl);
    endtask

    task automatic strobe();
        @(negedge clk);
        line_stb = 1'b1;
        @(negedge clk);
        line_stb = 1'b0;
        @(posedge clk);
        #1;
        model_latch();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk_v("R1 upper zero", col_up, '0);
        chk_v("R1 lower zero", col_lo, '0);
        chk_b("R1 chain_full", chain_full, 1'b0);
        pol = 1'b1;
        #1;
        // R11: polarity inverts every column immediately
        chk_v("R11 reset inverted", col_up, {COLS{1'b1}});

        // Table walk: R3 R4 R5 R6 R7 R10
        for (int e = 0; e < 5; e++) begin
            int n = int'(LINES[e][24:17]);
            @(negedge clk);
            pol = LINES[e][0];
            for (int k = 0; k < n; k++) begin
                send_nib(gen(LINES[e][16:9], k), gen(LINES[e][8:1], k));
                if (k == n / 2) chk_cols("R7 hold mid-line");
            end
            chk_b("R5 chain_full level", chain_full, (cnt == LNIBS));
            strobe();
            chk_cols("R3 R4 R6 R10 latched line");
            chk_b("R8 chain_full cleared", chain_full, 1'b0);
        end

        // R2: high level and rising edge accept nothing
        @(negedge clk);
        shift_clk = 1'b1;
        nib_up = 4'hF;
        nib_lo = 4'h1;
        repeat (3) begin
            @(negedge clk);
            nib_up = nib_up - 1'b1;
        end
        strobe();
        chk_cols("R2 no shift without fall");
        send_nib(4'h9, 4'h6);
        strobe();
        chk_cols("R2 single fall single nibble");

        // R9: coincident edges with slice 0 just full
        for (int k = 0; k < SNIBS; k++) send_nib(gen(8'h3B, k), gen(8'h71, k));
        @(negedge clk);
        nib_up = 4'hE;
        nib_lo = 4'hD;
        shift_clk = 1'b1;
        line_stb  = 1'b1;
        @(negedge clk);
        shift_clk = 1'b0;
        line_stb  = 1'b0;
        @(posedge clk);
        #1;
        model_latch();
        chk_cols("R9 coincident latch drops nibble");
        chk_b("R9 chain_full", chain_full, 1'b0);

        // R11: polarity toggle without a strobe
        @(negedge clk);
        pol = ~pol;
        #1;
        chk_cols("R11 polarity toggle");
        pol = ~pol;
        #1;
        chk_cols("R11 polarity restore");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule